// File: doc/BRIEF.md
# Clock frequency counter

This block estimates the frequency of one of several test clocks by counting its rising edges over a gate window timed by the block's own reference clock. The reference frequency is supplied in kHz, so the edge count can be scaled into a kHz value. The value is reported with a small fraction below it. Each test clock passes through its own synchronizer into the reference domain before its edges are counted.

A one-cycle pulse on the source-write strobe, together with a source code, starts a measurement at once. No separate start control exists. The gate length is a power of two reference cycles, picked by an interval exponent. When the gate closes, the block latches the scaled result. It then raises a done flag and grades the integer kHz value against a lower and an upper limit.

Top module: `fc_freq_counter`

## Requirements
- R1: After reset, running_o, done_o, pass_o, fast_o and slow_o are 0 and result_o is 0.
- R2: A cycle with src_wr_i high while running_o is low starts a measurement: on the next clock edge running_o goes to 1 and done_o goes to 0.
- R3: With interval exponent n latched at start, running_o stays high for exactly 2^n reference cycles, and done_o rises on the edge after running_o falls.
- R4: result_o equals floor(E * ref_khz * 32 / 2^n), where E is the number of synchronized rising edges of the selected test clock counted while the gate is open. Bits [24:5] hold the integer kHz and bits [4:0] hold 1/32 kHz steps.
- R5: Source code 0, and any code above the number of test clocks, selects a null source that has no edges. A measurement of it still runs its full gate and completes with result_o equal to 0.
- R6: A src_wr_i pulse while running_o is high is ignored. The gate length, the selected source and the result are those of the measurement already in progress.
- R7: At done, fast_o is 1 when the integer kHz exceeds max_khz_i, slow_o is 1 when it is below min_khz_i, and pass_o is 1 when neither holds. The limits are taken at start.
- R8: With min_khz_i = 0 and max_khz_i all ones, every completed measurement reports pass_o = 1.
- R9: done_o, result_o and the flags hold their values until the next accepted start.
- R10: Source code k, for k from 1 to NUM_SRC, measures test_clk_i[k-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| test_clk_i | input | NUM_SRC | Test clocks, asynchronous to clk |
| src_wr_i | input | 1 | Source write strobe; starts a measurement when idle |
| src_sel_i | input | SEL_W | Source code (0 = null, k = test_clk_i[k-1]) |
| ref_khz_i | input | 20 | Reference clock frequency in kHz |
| interval_i | input | 4 | Gate length exponent n (2^n reference cycles) |
| min_khz_i | input | 20 | Lower kHz limit |
| max_khz_i | input | 20 | Upper kHz limit |
| running_o | output | 1 | Gate open |
| done_o | output | 1 | Result valid |
| result_o | output | 25 | kHz result, integer in [24:5], fraction in [4:0] |
| pass_o | output | 1 | Result within limits |
| fast_o | output | 1 | Result above upper limit |
| slow_o | output | 1 | Result below lower limit |

## Verification
The checks assume that each test clock runs below half the reference rate, so that no synchronized edge is lost. They also assume that the configuration inputs stay steady during the cycle of an accepted strobe. The stimulus uses test periods of 3, 10 and 50 reference cycles, with phase offsets that never line up with a reference edge. The upper-limit check assumes max_khz_i is at least min_khz_i, and every limit pair the bench applies keeps that order. Because the phase between test and reference clocks is not fixed, the edge count may differ from the nominal value by one. The bench therefore accepts the scaled value of the nominal count or of either neighbour.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;

    localparam int KHZ_W  = 20;
    localparam int FRAC_W = 5;
    localparam int INT_W  = 4;
    localparam int TMR_W  = 1 << INT_W;
    localparam int CNT_W  = TMR_W;
    localparam int RES_W  = KHZ_W + FRAC_W;
    localparam int PROD_W = CNT_W + KHZ_W + FRAC_W;

    typedef struct packed {
        logic [KHZ_W-1:0] ref_khz;
        logic [INT_W-1:0] interval;
        logic [KHZ_W-1:0] min_khz;
        logic [KHZ_W-1:0] max_khz;
    } fc_cfg_t;

    typedef struct packed {
        logic pass;
        logic fast;
        logic slow;
    } fc_verdict_t;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_OPEN = 1'b1
    } fc_gate_e;

    function automatic fc_verdict_t fc_judge(
        input logic [KHZ_W-1:0] khz,
        input logic [KHZ_W-1:0] lo,
        input logic [KHZ_W-1:0] hi
    );
        fc_verdict_t v;
        v.fast = (khz > hi);
        v.slow = (khz < lo);
        v.pass = !(v.fast || v.slow);
        return v;
    endfunction

endpackage

// File: rtl/fc_edge_sync.sv
`timescale 1ns/1ps
module fc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign edge_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fc_gate_ctrl.sv
`timescale 1ns/1ps
module fc_gate_ctrl
    import fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [INT_W-1:0] interval_i,
    input  logic             edge_i,
    output logic             running_o,
    output logic             finish_o,
    output logic [CNT_W-1:0] count_o
);
    fc_gate_e         state_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_IDLE;
            tmr_q   <= '0;
            cnt_q   <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                GATE_IDLE: begin
                    if (start_i) begin
                        state_q <= GATE_OPEN;
                        tmr_q   <= (TMR_W'(1) << interval_i) - TMR_W'(1);
                        cnt_q   <= '0;
                    end
                end
                GATE_OPEN: begin
                    cnt_q <= cnt_q + CNT_W'(edge_i);
                    if (tmr_q == '0) begin
                        state_q <= GATE_IDLE;
                        fin_q   <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q - TMR_W'(1);
                    end
                end
                default: state_q <= GATE_IDLE;
            endcase
        end
    end

    assign running_o = (state_q == GATE_OPEN);
    assign finish_o  = fin_q;
    assign count_o   = cnt_q;
endmodule

// File: rtl/fc_scale.sv
`timescale 1ns/1ps
module fc_scale
    import fc_pkg::*;
(
    input  logic [CNT_W-1:0] count_i,
    input  logic [KHZ_W-1:0] ref_khz_i,
    input  logic [INT_W-1:0] interval_i,
    output logic [RES_W-1:0] result_o
);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        prod     = (PROD_W'(count_i) * PROD_W'(ref_khz_i)) << FRAC_W;
        scaled   = prod >> interval_i;
        result_o = scaled[RES_W-1:0];
    end
endmodule

// File: rtl/fc_freq_counter.sv
`timescale 1ns/1ps
module fc_freq_counter
    import fc_pkg::*;
#(
    parameter int NUM_SRC     = 3,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] test_clk_i,
    input  logic               src_wr_i,
    input  logic [SEL_W-1:0]   src_sel_i,
    input  logic [KHZ_W-1:0]   ref_khz_i,
    input  logic [INT_W-1:0]   interval_i,
    input  logic [KHZ_W-1:0]   min_khz_i,
    input  logic [KHZ_W-1:0]   max_khz_i,
    output logic               running_o,
    output logic               done_o,
    output logic [RES_W-1:0]   result_o,
    output logic               pass_o,
    output logic               fast_o,
    output logic               slow_o
);
    logic [NUM_SRC-1:0] edge_v;
    logic [SEL_W-1:0]   sel_q;
    fc_cfg_t            cfg_q;
    fc_verdict_t        verdict_q;
    fc_verdict_t        verdict_d;
    logic               sel_edge;
    logic               start;
    logic               running;
    logic               finish;
    logic [CNT_W-1:0]   count;
    logic [RES_W-1:0]   scaled;
    logic [RES_W-1:0]   result_q;
    logic               done_q;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_sync
            fc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst     (rst),
                .async_i (test_clk_i[g]),
                .edge_o  (edge_v[g])
            );
        end
    endgenerate

    always_comb begin
        sel_edge = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_q == SEL_W'(i + 1)) sel_edge = edge_v[i];
        end
    end

    assign start = src_wr_i && !running;

    fc_gate_ctrl u_gate (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .interval_i (interval_i),
        .edge_i     (sel_edge),
        .running_o  (running),
        .finish_o   (finish),
        .count_o    (count)
    );

    fc_scale u_scale (
        .count_i    (count),
        .ref_khz_i  (cfg_q.ref_khz),
        .interval_i (cfg_q.interval),
        .result_o   (scaled)
    );

    assign verdict_d = fc_judge(scaled[RES_W-1:FRAC_W], cfg_q.min_khz, cfg_q.max_khz);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            cfg_q     <= '0;
            verdict_q <= '0;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else if (start) begin
            sel_q          <= src_sel_i;
            cfg_q.ref_khz  <= ref_khz_i;
            cfg_q.interval <= interval_i;
            cfg_q.min_khz  <= min_khz_i;
            cfg_q.max_khz  <= max_khz_i;
            done_q         <= 1'b0;
        end else if (finish) begin
            result_q  <= scaled;
            verdict_q <= verdict_d;
            done_q    <= 1'b1;
        end
    end

    assign running_o = running;
    assign done_o    = done_q;
    assign result_o  = result_q;
    assign pass_o    = verdict_q.pass;
    assign fast_o    = verdict_q.fast;
    assign slow_o    = verdict_q.slow;
endmodule

// File: rtl/fc_freq_counter_chk.sv
`timescale 1ns/1ps
module fc_freq_counter_chk
    import fc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             src_wr_i,
    input logic [INT_W-1:0] interval_i,
    input logic [KHZ_W-1:0] min_khz_i,
    input logic [KHZ_W-1:0] max_khz_i,
    input logic             running_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic             pass_o,
    input logic             fast_o,
    input logic             slow_o
);
    logic [TMR_W:0]   gate_cnt;
    logic [INT_W-1:0] lat_n;
    logic [KHZ_W-1:0] lat_min;
    logic [KHZ_W-1:0] lat_max;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_cnt <= '0;
            lat_n    <= '0;
            lat_min  <= '0;
            lat_max  <= '0;
        end else if (src_wr_i && !running_o) begin
            gate_cnt <= '0;
            lat_n    <= interval_i;
            lat_min  <= min_khz_i;
            lat_max  <= max_khz_i;
        end else if (running_o) begin
            gate_cnt <= gate_cnt + 1'b1;
        end
    end

    a_r1_idle_excl: assert property (@(posedge clk) disable iff (rst)
        running_o |-> !done_o);

    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (src_wr_i && !running_o) |=> (running_o && !done_o));

    a_r3_gate_len: assert property (@(posedge clk) disable iff (rst)
        $fell(running_o) |-> (gate_cnt == ((TMR_W + 1)'(1) << lat_n)));

    a_r3_done_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(running_o) |=> done_o);

    a_r6_ignore_write: assert property (@(posedge clk) disable iff (rst)
        (running_o && src_wr_i && ((gate_cnt + 1'b1) < ((TMR_W + 1)'(1) << lat_n))) |=> running_o);

    a_r7_fast: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (fast_o == (result_o[RES_W-1:FRAC_W] > lat_max)));

    a_r7_slow: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (slow_o == (result_o[RES_W-1:FRAC_W] < lat_min)));

    a_r7_one_verdict: assert property (@(posedge clk) disable iff (rst)
        (done_o && lat_min <= lat_max) |-> $onehot0({pass_o, fast_o, slow_o}) && (pass_o || fast_o || slow_o));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !src_wr_i) |=> (done_o && $stable(result_o) && $stable({pass_o, fast_o, slow_o})));
endmodule

bind fc_freq_counter fc_freq_counter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_wr_i   (src_wr_i),
    .interval_i (interval_i),
    .min_khz_i  (min_khz_i),
    .max_khz_i  (max_khz_i),
    .running_o  (running_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .pass_o     (pass_o),
    .fast_o     (fast_o),
    .slow_o     (slow_o)
);

// File: tb/fc_freq_counter_tb_top.sv
`timescale 1ns/1ps
module fc_freq_counter_tb_top;
    import fc_pkg::*;

    localparam int NSRC  = 3;
    localparam int SELW  = $clog2(NSRC + 1);
    localparam int REFKHZ = 50000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NSRC-1:0]  tclk = '0;
    logic             src_wr = 1'b0;
    logic [SELW-1:0]  src_sel = '0;
    logic [KHZ_W-1:0] ref_khz = KHZ_W'(REFKHZ);
    logic [INT_W-1:0] interval = 4'd10;
    logic [KHZ_W-1:0] min_khz = '0;
    logic [KHZ_W-1:0] max_khz = '1;
    logic             running, done, pass, fast, slow;
    logic [RES_W-1:0] result;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    initial begin #3;  forever #100 tclk[0] = ~tclk[0]; end
    initial begin #7;  forever #30  tclk[1] = ~tclk[1]; end
    initial begin #13; forever #500 tclk[2] = ~tclk[2]; end

    fc_freq_counter #(.NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst(rst), .test_clk_i(tclk), .src_wr_i(src_wr),
        .src_sel_i(src_sel), .ref_khz_i(ref_khz), .interval_i(interval),
        .min_khz_i(min_khz), .max_khz_i(max_khz), .running_o(running),
        .done_o(done), .result_o(result), .pass_o(pass), .fast_o(fast),
        .slow_o(slow)
    );

    function automatic longint scale(input longint c, input int n);
        return (c * REFKHZ * 32) >> n;
    endfunction

    function automatic int period_of(input int sel);
        case (sel)
            1: return 200;
            2: return 60;
            3: return 1000;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_result(input string req, input int sel, input int n);
        longint nom;
        bit ok;
        nom = (longint'(1) << n) * 20 / period_of(sel);
        ok = (result == scale(nom, n)) || (result == scale(nom + 1, n)) ||
             (nom > 0 && result == scale(nom - 1, n));
        chk(ok, req, result, scale(nom, n));
    endtask

    // Starts a run and measures the gate; an optional stray write at cycle 5.
    task automatic run(input int sel, input int n, input bit stray, output int glen);
        @(negedge clk);
        interval = INT_W'(n);
        src_sel  = SELW'(sel);
        src_wr   = 1'b1;
        @(negedge clk);
        src_wr   = 1'b0;
        chk(running === 1'b1 && done === 1'b0, "R2 start", {running, done}, 2'b10);
        glen = 0;
        while (running === 1'b1 && glen < 70000) begin
            glen++;
            if (stray && glen == 5) begin
                src_sel  = SELW'((sel % NSRC) + 1);
                interval = INT_W'(2);
                src_wr   = 1'b1;
            end else begin
                src_wr = 1'b0;
            end
            @(negedge clk);
        end
        src_wr = 1'b0;
        chk(done === 1'b0, "R3 done one cycle after gate", done, 0);
        @(negedge clk);
        chk(done === 1'b1, "R3 done raised", done, 1);
    endtask

    task automatic t_reset;
        chk(running === 0 && done === 0 && pass === 0 && fast === 0 && slow === 0,
            "R1 reset flags", {running, done, pass, fast, slow}, 0);
        chk(result === '0, "R1 reset result", result, 0);
    endtask

    task automatic t_sources;
        int glen;
        for (int s = 1; s <= NSRC; s++) begin
            run(s, 10, 0, glen);
            chk(glen == 1024, "R3 gate length", glen, 1024);
            chk_result("R4 R10 scaled kHz", s, 10);
            chk(pass === 1'b1, "R8 limits disabled", pass, 1);
        end
    endtask

    task automatic t_short_gate;
        int glen;
        run(2, 6, 0, glen);
        chk(glen == 64, "R3 short gate", glen, 64);
        chk_result("R4 short gate", 2, 6);
    endtask

    task automatic t_null;
        int glen;
        run(0, 8, 0, glen);
        chk(glen == 256 && result === '0, "R5 null code 0", result, 0);
        run(NSRC + 1 < (1 << SELW) ? NSRC + 1 : 0, 8, 0, glen);
        chk(glen == 256 && result === '0, "R5 null out of range", result, 0);
    endtask

    task automatic t_ignored;
        int glen;
        run(3, 10, 1, glen);
        chk(glen == 1024, "R6 gate unchanged", glen, 1024);
        chk_result("R6 source unchanged", 3, 10);
    endtask

    task automatic t_limits;
        int glen;
        min_khz = 20'd0;    max_khz = 20'd900;
        run(3, 10, 0, glen);
        chk(fast === 1 && slow === 0 && pass === 0, "R7 fast", {pass, fast, slow}, 3'b010);
        min_khz = 20'd2000; max_khz = 20'd5000;
        run(3, 10, 0, glen);
        chk(slow === 1 && fast === 0 && pass === 0, "R7 slow", {pass, fast, slow}, 3'b001);
        min_khz = 20'd900;  max_khz = 20'd1100;
        run(3, 10, 0, glen);
        chk(pass === 1 && fast === 0 && slow === 0, "R7 pass", {pass, fast, slow}, 3'b100);
        min_khz = '0;       max_khz = '1;
        run(2, 10, 0, glen);
        chk(pass === 1, "R8 all-ones max with fast source", pass, 1);
    endtask

    task automatic t_hold;
        logic [RES_W-1:0] r0;
        r0 = result;
        repeat (20) @(negedge clk);
        chk(done === 1 && result === r0 && pass === 1, "R9 hold", result, r0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sources();
        t_short_gate();
        t_null();
        t_ignored();
        t_limits();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule